// File: doc/BRIEF.md
# Untrained Paced Transfer Start Sequencer

This block is the target-side controller that opens a double-transition paced data phase when no training pattern is sent. It runs on a clock whose period equals one negotiated transfer period. A start request moves it through a bus-settle wait, with SEL still driven, and then a deskew gap with SEL released. After that it launches a free-running REQ clock together with a P1 phase signal at half the REQ rate. P1 keeps a fixed, data-invalid phase relation to REQ for a programmable preamble. When the preamble ends, the block reports that data may be marked valid, and both clocks keep running.

The preamble length is a runtime value. It can be read as a count of P1 level changes or as a minimum number of transfer-period clocks. The settle wait is chosen from two parameterised lengths: a short one, and a long one used when the previous phase was a data-out phase. A stop input aborts the sequence at any point.

States: `ST_IDLE`, `ST_SETTLE`, `ST_DESKEW`, `ST_PREAMBLE`, `ST_DATA_OK`. Transitions:
- `ST_IDLE`→`ST_SETTLE` on start.
- `ST_SETTLE`→`ST_DESKEW` when the settle count expires.
- `ST_DESKEW`→`ST_PREAMBLE` after two deskew delays.
- `ST_PREAMBLE`→`ST_DATA_OK` when the preamble count expires.
- Any state→`ST_IDLE` on stop.

Top module: `paced_start_seq`

## Requirements
- R1: After reset, and whenever idle, `sel_o`, `req_o`, `p1_o`, `data_ok_o` and `done_o` are all low.
- R2: A start accepted in idle raises `sel_o` from the next cycle for SETTLE_SHORT_CYC cycles. If `prev_out_i` was high when start was sampled, it stays up for SETTLE_LONG_CYC cycles instead.
- R3: After `sel_o` falls, all outputs stay low for exactly 2*DESKEW_CYC cycles, and then `req_o` is asserted for the first time.
- R4: From its first assertion, `req_o` is high in the first cycle and changes level on every cycle while the phase runs.
- R5: `p1_o` rises in the same cycle as the first `req_o` assertion, and each P1 level lasts exactly two cycles. P1 is high in the cycles where the REQ toggle count modulo 4 is 0 or 1.
- R6: With `time_mode_i` low at start, the preamble lasts 2*N cycles, where N is `pre_len_i` (0 is treated as 1). `data_ok_o` then rises and stays high while REQ and P1 keep running.
- R7: With `time_mode_i` high at start, the preamble lasts N cycles rounded up to an even count, with a minimum of 2.
- R8: `done_o` is high for exactly one cycle: the first cycle in which `data_ok_o` is high.
- R9: `stop_i` sampled high sends the block to idle, with all outputs low on the next cycle. A stop takes priority over a start in the same cycle.
- R10: A start while not idle is ignored. Changes to `prev_out_i`, `time_mode_i` and `pre_len_i` after the start was accepted have no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one transfer period |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin the untrained data phase |
| prev_out_i | input | 1 | Previous phase was data-out (selects long settle) |
| time_mode_i | input | 1 | 1: preamble length in clocks, 0: in P1 transitions |
| pre_len_i | input | PRE_W | Preamble length value |
| stop_i | input | 1 | Abort, return to idle |
| sel_o | output | 1 | SEL held during the settle wait |
| req_o | output | 1 | Free-running REQ clock |
| p1_o | output | 1 | P1 phase signal at half the REQ rate |
| data_ok_o | output | 1 | Data may be marked valid |
| done_o | output | 1 | One-cycle pulse on entering the data-valid-allowed state |

## Verification
The bench compares every output on every cycle against a behavioural timeline model. It goes after the off-by-one boundaries: a settle or deskew wait one cycle short would start REQ early, and a preamble counted in REQ edges rather than P1 levels would raise `data_ok_o` at half the proper time. A zero length and odd lengths in time mode exercise the clamping and rounding rules; a design that skipped them would end the preamble mid-level or at once. Stopping during the preamble, a stop coinciding with a start, and a restart while busy with altered configuration inputs each expose a design that leaks configuration into a running sequence or fails to drop its clocks.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_DESKEW,
        ST_PREAMBLE,
        ST_DATA_OK
    } pss_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pss_len_calc.sv
// Latches the preamble configuration at start and converts it into a cycle count.
module pss_len_calc #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             time_mode_i,
    input  logic [PRE_W-1:0] len_i,
    output logic [PRE_W:0]   cyc_o
);
    localparam int OW = PRE_W + 1;

    logic [PRE_W:0] cyc_d;
    logic [PRE_W:0] len_ext;

    assign len_ext = {1'b0, len_i};

    always_comb begin
        if (len_i == '0) begin
            cyc_d = OW'(2);
        end else if (time_mode_i) begin
            cyc_d = len_ext + OW'(len_i[0]);
        end else begin
            cyc_d = {len_i, 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_o <= OW'(2);
        end else if (load_i) begin
            cyc_o <= cyc_d;
        end
    end
endmodule

// File: rtl/pss_timer.sv
// Cycle counter flagging the last cycle of a programmed interval.
module pss_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic [CW-1:0] limit_i,
    output logic          last_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign last_o = (cnt_q == (limit_i - CW'(1)));
endmodule

// File: rtl/pss_pace.sv
// REQ at the transfer rate and P1 at half of it, both starting high.
module pss_pace (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic req_o,
    output logic p1_o
);
    logic [1:0] ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= 2'd0;
        end else if (run_i) begin
            ph_q <= ph_q + 2'd1;
        end else begin
            ph_q <= 2'd0;
        end
    end

    assign req_o = run_i & ~ph_q[0];
    assign p1_o  = run_i & ~ph_q[1];
endmodule

// File: rtl/paced_start_seq.sv
module paced_start_seq
    import pss_pkg::*;
#(
    parameter int SETTLE_SHORT_CYC = 8,
    parameter int SETTLE_LONG_CYC  = 16,
    parameter int DESKEW_CYC       = 2,
    parameter int PRE_W            = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             prev_out_i,
    input  logic             time_mode_i,
    input  logic [PRE_W-1:0] pre_len_i,
    input  logic             stop_i,
    output logic             sel_o,
    output logic             req_o,
    output logic             p1_o,
    output logic             data_ok_o,
    output logic             done_o
);
    localparam int MAXC = max2(max2(SETTLE_LONG_CYC, SETTLE_SHORT_CYC),
                               max2(2 * DESKEW_CYC, 2 ** (PRE_W + 1)));
    localparam int CW   = $clog2(MAXC + 1);

    pss_state_e     state_q, state_d;
    logic           long_q;
    logic           done_q;
    logic           accept;
    logic           tmr_last;
    logic           tmr_clear;
    logic [CW-1:0]  limit;
    logic [PRE_W:0] pre_cyc;
    logic           run;

    assign accept = (state_q == ST_IDLE) && start_i && !stop_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     if (start_i)  state_d = ST_SETTLE;
                ST_SETTLE:   if (tmr_last) state_d = ST_DESKEW;
                ST_DESKEW:   if (tmr_last) state_d = ST_PREAMBLE;
                ST_PREAMBLE: if (tmr_last) state_d = ST_DATA_OK;
                ST_DATA_OK:                state_d = ST_DATA_OK;
                default:                   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            long_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                long_q <= prev_out_i;
            end
            done_q <= (state_d == ST_DATA_OK) && (state_q != ST_DATA_OK);
        end
    end

    // interval selection per state
    always_comb begin
        unique case (state_q)
            ST_SETTLE:   limit = long_q ? CW'(SETTLE_LONG_CYC) : CW'(SETTLE_SHORT_CYC);
            ST_DESKEW:   limit = CW'(2 * DESKEW_CYC);
            ST_PREAMBLE: limit = CW'(pre_cyc);
            default:     limit = CW'(1);
        endcase
    end

    assign tmr_clear = (state_d != state_q) || (state_q == ST_IDLE) ||
                       (state_q == ST_DATA_OK);
    assign run       = (state_q == ST_PREAMBLE) || (state_q == ST_DATA_OK);

    pss_len_calc #(.PRE_W(PRE_W)) u_len (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .time_mode_i (time_mode_i),
        .len_i       (pre_len_i),
        .cyc_o       (pre_cyc)
    );

    pss_timer #(.CW(CW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (tmr_clear),
        .limit_i (limit),
        .last_o  (tmr_last)
    );

    pss_pace u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run),
        .req_o (req_o),
        .p1_o  (p1_o)
    );

    // state-decoded outputs
    always_comb begin
        sel_o     = (state_q == ST_SETTLE);
        data_ok_o = (state_q == ST_DATA_OK);
        done_o    = done_q;
    end
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
    parameter int DESKEW_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic stop_i,
    input logic sel_o,
    input logic req_o,
    input logic p1_o,
    input logic data_ok_o,
    input logic done_o
);
    localparam int GMAX = 2 * DESKEW_CYC + 1;
    localparam int GW   = $clog2(GMAX + 1);

    logic [GW-1:0] gap_q;

    // cycles since SEL was last seen high, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= GW'(GMAX);
        end else if (sel_o) begin
            gap_q <= '0;
        end else if (gap_q != GW'(GMAX)) begin
            gap_q <= gap_q + GW'(1);
        end
    end

    p_deskew_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (gap_q >= GW'(2 * DESKEW_CYC)));

    p_req_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ok_o && $past(data_ok_o)) |-> (req_o != $past(req_o)));

    p_p1_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ok_o && $past(data_ok_o) && (p1_o != $past(p1_o)))
            |=> (!data_ok_o || $stable(p1_o)));

    p_done_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ok_o) |-> done_o);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!sel_o && !req_o && !p1_o && !data_ok_o && !done_o));

    p_sel_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o |-> (!req_o && !p1_o && !data_ok_o));
endmodule

bind paced_start_seq pss_checker #(.DESKEW_CYC(DESKEW_CYC)) u_pss_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_i    (stop_i),
    .sel_o     (sel_o),
    .req_o     (req_o),
    .p1_o      (p1_o),
    .data_ok_o (data_ok_o),
    .done_o    (done_o)
);

// File: tb/test_paced_start_seq.sv
`timescale 1ns/1ps
module test_paced_start_seq;
    localparam int SS = 8;
    localparam int SL = 16;
    localparam int DK = 2;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          prev_out_i = 1'b0;
    logic          time_mode_i = 1'b0;
    logic [PW-1:0] pre_len_i = '0;
    logic          stop_i = 1'b0;
    logic          sel_o, req_o, p1_o, data_ok_o, done_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string tag = "R1";

    // behavioural model state
    int m_ph = 0;      // 0 idle 1 settle 2 deskew 3 preamble 4 data ok
    int m_left = 0;
    int m_tick = 0;
    int m_len = 0;
    int m_done = 0;

    paced_start_seq #(
        .SETTLE_SHORT_CYC(SS), .SETTLE_LONG_CYC(SL),
        .DESKEW_CYC(DK), .PRE_W(PW)
    ) i_paced_start_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .prev_out_i(prev_out_i),
        .time_mode_i(time_mode_i), .pre_len_i(pre_len_i), .stop_i(stop_i),
        .sel_o(sel_o), .req_o(req_o), .p1_o(p1_o),
        .data_ok_o(data_ok_o), .done_o(done_o)
    );

    always #5 clk = ~clk;

    function automatic int pre_cycles(input int n, input bit tm);
        if (n == 0) return 2;
        if (tm) return n + (n % 2);
        return 2 * n;
    endfunction

    // model update on each edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n || stop_i) begin
            m_ph = 0; m_done = 0;
        end else begin
            m_done = 0;
            case (m_ph)
                0: if (start_i) begin
                    m_ph = 1; m_left = prev_out_i ? SL : SS;
                    m_len = pre_cycles(int'(pre_len_i), time_mode_i);
                end
                1: begin m_left--; if (m_left == 0) begin m_ph = 2; m_left = 2 * DK; end end
                2: begin m_left--; if (m_left == 0) begin m_ph = 3; m_left = m_len; m_tick = 0; end end
                3: begin
                    m_tick++; m_left--;
                    if (m_left == 0) begin m_ph = 4; m_done = 1; end
                end
                default: m_tick++;
            endcase
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s (%s) cycle %0d: actual=%0b expected=%0b", req, tag, cyc, act, exp);
        end
    endtask

    // compare every cycle, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk("R2 sel", sel_o, m_ph == 1);
            chk("R4 req", req_o, (m_ph >= 3) && (m_tick % 2 == 0));
            chk("R5 p1", p1_o, (m_ph >= 3) && ((m_tick / 2) % 2 == 0));
            chk("R6 data_ok", data_ok_o, m_ph == 4);
            chk("R8 done", done_o, m_done == 1);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic launch(input bit prev, input bit tm, input int len);
        @(negedge clk);
        prev_out_i = prev; time_mode_i = tm; pre_len_i = PW'(len); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic halt();
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        // R1: reset values
        #1;
        chk("R1 reset sel", sel_o, 1'b0);
        chk("R1 reset req", req_o, 1'b0);
        chk("R1 reset data_ok", data_ok_o, 1'b0);
        tick(3);
        rst_n = 1'b1;
        tick(4);

        tag = "R2 R3 R6 short settle, 8 transitions";
        launch(1'b0, 1'b0, 8);
        tick(SS + 2 * DK + 16 + 10);
        tag = "R9 stop from data ok";
        halt();
        tick(3);

        tag = "R2 long settle, 3 transitions";
        launch(1'b1, 1'b0, 3);
        tick(SL + 2 * DK + 6 + 6);
        halt();

        tag = "R7 time mode odd 7";
        launch(1'b0, 1'b1, 7);
        tick(SS + 2 * DK + 8 + 5);
        halt();

        tag = "R7 time mode zero";
        launch(1'b0, 1'b1, 0);
        tick(SS + 2 * DK + 2 + 5);
        halt();

        tag = "R6 transition mode zero";
        launch(1'b1, 1'b0, 0);
        tick(SL + 2 * DK + 2 + 5);
        halt();

        tag = "R7 time mode even 10";
        launch(1'b0, 1'b1, 10);
        tick(SS + 2 * DK + 10 + 5);
        halt();

        tag = "R10 restart while busy with changed config";
        launch(1'b0, 1'b0, 4);
        tick(3);
        launch(1'b1, 1'b1, 1);
        tick(SS + 2 * DK);
        launch(1'b1, 1'b1, 1);
        tick(20);
        halt();

        tag = "R9 stop during preamble";
        launch(1'b0, 1'b0, 20);
        tick(SS + 2 * DK + 7);
        halt();
        tick(5);

        tag = "R9 stop with start together";
        @(negedge clk);
        start_i = 1'b1; stop_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
        tick(4);

        tag = "R6 long preamble 255";
        launch(1'b0, 1'b0, 255);
        tick(SS + 2 * DK + 510 + 8);
        halt();
        tick(4);

        finish_run();
    end

    initial begin
        tick(100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule